// File: doc/BRIEF.md
# Prescaled Tick Timer

This block is a small up-counting timer that gives a periodic tick, such as the refresh interval for a multiplexed display. Software configures it with a single packed control byte. The byte holds a run bit, a width-mode bit, a prescaler-bypass bit and a three-bit divide selector. A writable count register sets the starting point of each period. Every overflow sets a sticky flag. When the interrupt enable is high, the flag raises the interrupt request. The service routine then writes the preload value back into the count and clears the flag with a write-one strobe.

The tick period is set by the preload value and the prescale ratio. With a preload of P in 8-bit mode and a ratio of R, the flag sets (256 − P) × R clocks after the count write. For example, a control value of 0xC5 runs the counter in 8-bit mode at divide-by-64. A preload of 100 then gives one flag every 9984 clocks. A clear width-mode bit chains a high byte to the counter, which makes it 16 bits wide.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset, both count bytes, the control byte, the flag and the interrupt request are all zero.
- R2: The control byte uses these fields: bit 7 is run, bit 6 is narrow (8-bit) mode, bit 3 is prescaler bypass and bits 2:0 hold the divide selector n. The divide ratio is 2^(n+1). The byte written is returned unchanged on `ctrl_q`.
- R3: While running with bypass clear, the count advances by one every 2^(n+1) clocks. The first step comes 2^(n+1) clocks after the last control or count write. With bypass set, the count advances on every clock.
- R4: In narrow mode the low byte wraps from 0xFF to 0x00 and sets the flag. The high byte is left unchanged.
- R5: In wide mode the low byte carries into the high byte. The flag sets only on the wrap from 0xFFFF to 0x0000.
- R6: In narrow mode, with preload P written to the low byte and divide ratio R, the flag rises exactly (256 − P) × R clocks after the write.
- R7: Any write to the control byte or to either count byte clears the prescaler's internal count.
- R8: A count write takes effect in the next cycle. In the cycle of the write, it suppresses any increment or overflow.
- R9: The flag stays set until `flag_clr` is pulsed. If an overflow and a clear fall in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when the flag is set and `irq_en` is high.
- R11: While run is low, the count holds its value, the prescaler stays cleared and the flag cannot be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write strobe for the control byte |
| cnt_we | input | 1 | Write strobe for a count byte |
| cnt_sel | input | 1 | Count byte to write: 0 selects the low byte, 1 the high byte |
| wdata | input | 8 | Write data for control and count |
| flag_clr | input | 1 | Write-one strobe that clears the flag |
| irq_en | input | 1 | Interrupt enable |
| ctrl_q | output | 8 | Current control byte |
| count_lo | output | 8 | Low count byte |
| count_hi | output | 8 | High count byte |
| flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures the overflow distance for a preload of 100 at divide-by-64 to the exact clock. If a design let the prescaler run on across writes, or counted 255 − P steps instead of 256 − P, the flag would come early or late. The bench also re-writes the count part-way through a prescale period. A design that did not restart the prescaler would then step too soon. It also lands a clear strobe on the cycle of an overflow, where a design that let the clear win would lose the event. In narrow mode the bench checks that the high byte does not move at the low-byte wrap. In wide mode it checks that the flag does not rise at 0x00FF and only rises at 0xFFFF; a design that carried or flagged on the wrong byte would fail these.

// File: rtl/tick_tmr_pkg.sv
package tick_tmr_pkg;

    parameter int TMR_W     = 8;
    parameter int DIV_SEL_W = 3;
    localparam int PS_W     = 1 << DIV_SEL_W;

    // Packed control byte, MSB first: run, narrow, two spare bits, bypass, divide select
    typedef struct packed {
        logic                 run;
        logic                 narrow;
        logic [1:0]           spare;
        logic                 bypass;
        logic [DIV_SEL_W-1:0] div_sel;
    } tmr_ctrl_t;

    // Low (sel+1) bits set: the prescaler fires when all of them are ones
    function automatic logic [PS_W-1:0] div_mask(input logic [DIV_SEL_W-1:0] sel);
        logic [PS_W-1:0] ones;
        ones = '1;
        return ~(ones << (int'(sel) + 1));
    endfunction

endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
    import tick_tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we_i,
    input  logic [7:0]      wdata_i,
    output tmr_ctrl_t       ctrl_o
);

    tmr_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (we_i) begin
            ctrl_q <= tmr_ctrl_t'(wdata_i);
        end
    end

    assign ctrl_o = ctrl_q;

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (ctrl_o == tmr_ctrl_t'($past(wdata_i)))); // R2

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tick_tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_i,
    input  logic                 bypass_i,
    input  logic [DIV_SEL_W-1:0] div_sel_i,
    input  logic                 clr_i,
    output logic                 tick_o
);

    logic [PS_W-1:0] pc_q;
    logic [PS_W-1:0] mask;

    assign mask = div_mask(div_sel_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i || !en_i) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // Free-running binary count: the low bits are all ones once every 2^(n+1) clocks
    always_comb begin
        if (!en_i) begin
            tick_o = 1'b0;
        end else if (bypass_i) begin
            tick_o = 1'b1;
        end else begin
            tick_o = ((pc_q & mask) == mask);
        end
    end

    AST_PS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (pc_q == '0)); // R7

    AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> !tick_o); // R11

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         narrow_i,
    input  logic         wr_lo_i,
    input  logic         wr_hi_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o,
    output logic         ovf_o
);

    localparam logic [W-1:0] TOP = '1;

    logic wr_any;
    logic step;
    logic lo_top;
    logic hi_top;
    logic carry_hi;

    assign wr_any   = wr_lo_i | wr_hi_i;
    assign step     = tick_i & ~wr_any;
    assign lo_top   = (lo_o == TOP);
    assign hi_top   = (hi_o == TOP);
    assign carry_hi = step & lo_top & ~narrow_i;
    assign ovf_o    = step & lo_top & (narrow_i | hi_top);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_o <= '0;
            hi_o <= '0;
        end else begin
            if (wr_lo_i) begin
                lo_o <= wdata_i;
            end else if (step) begin
                lo_o <= lo_o + 1'b1;
            end
            if (wr_hi_i) begin
                hi_o <= wdata_i;
            end else if (carry_hi) begin
                hi_o <= hi_o + 1'b1;
            end
        end
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_lo_i |=> (lo_o == $past(wdata_i))); // R8

    AST_NARROW_HI_KEEP: assert property (@(posedge clk) disable iff (rst)
        (narrow_i && !wr_hi_i) |=> $stable(hi_o)); // R4

    AST_WIDE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !narrow_i) |=> (lo_o == '0 && hi_o == '0)); // R5

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o); // R9

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o); // R9

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic       cnt_we,
    input  logic       cnt_sel,
    input  logic [7:0] wdata,
    input  logic       flag_clr,
    input  logic       irq_en,
    output logic [7:0] ctrl_q,
    output logic [7:0] count_lo,
    output logic [7:0] count_hi,
    output logic       flag,
    output logic       irq
);

    tmr_ctrl_t ctrl;
    logic      tick;
    logic      ovf;
    logic      ps_clr;
    logic      wr_lo;
    logic      wr_hi;

    assign ps_clr = ctrl_we | cnt_we;
    assign wr_lo  = cnt_we & ~cnt_sel;
    assign wr_hi  = cnt_we & cnt_sel;

    tmr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we_i    (ctrl_we),
        .wdata_i (wdata),
        .ctrl_o  (ctrl)
    );

    tmr_prescaler u_ps (
        .clk       (clk),
        .rst       (rst),
        .en_i      (ctrl.run),
        .bypass_i  (ctrl.bypass),
        .div_sel_i (ctrl.div_sel),
        .clr_i     (ps_clr),
        .tick_o    (tick)
    );

    tmr_counter #(.W(TMR_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .narrow_i (ctrl.narrow),
        .wr_lo_i  (wr_lo),
        .wr_hi_i  (wr_hi),
        .wdata_i  (wdata),
        .lo_o     (count_lo),
        .hi_o     (count_hi),
        .ovf_o    (ovf)
    );

    tmr_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ovf),
        .clr_i  (flag_clr),
        .flag_o (flag)
    );

    assign ctrl_q = 8'(ctrl);
    assign irq    = flag & irq_en;

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag); // R10

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !cnt_we) |=> $stable(count_lo)); // R11

    AST_NO_FLAG_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !flag) |=> !flag); // R11

endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;

    logic       clk = 1'b0;
    logic       rst;
    logic       ctrl_we, cnt_we, cnt_sel, flag_clr, irq_en;
    logic [7:0] wdata;
    logic [7:0] ctrl_q, count_lo, count_hi;
    logic       flag, irq;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    tick_timer dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .cnt_we(cnt_we), .cnt_sel(cnt_sel),
        .wdata(wdata), .flag_clr(flag_clr), .irq_en(irq_en), .ctrl_q(ctrl_q),
        .count_lo(count_lo), .count_hi(count_hi), .flag(flag), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1; wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic sel, input logic [7:0] v);
        cnt_we = 1'b1; cnt_sel = sel; wdata = v;
        @(negedge clk);
        cnt_we = 1'b0; cnt_sel = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 count_lo", count_lo, 0);
        check("R1 count_hi", count_hi, 0);
        check("R1 ctrl", ctrl_q, 0);
        check("R1 flag", flag, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_disabled_hold();
        wr_ctrl(8'h48);
        check("R2 ctrl readback", ctrl_q, 8'h48);
        wr_cnt(1'b0, 8'hFE);
        wait_n(300);
        check("R11 count held", count_lo, 8'hFE);
        check("R11 no flag", flag, 0);
    endtask

    task automatic t_preload_period();
        wr_ctrl(8'hC5);
        wr_cnt(1'b0, 8'd100);
        wait_n(9983);
        check("R6 count before wrap", count_lo, 8'hFF);
        check("R6 flag not yet", flag, 0);
        wait_n(1);
        check("R6 flag at (256-100)*64", flag, 1);
        check("R4 narrow wrap lo", count_lo, 8'h00);
        irq_en = 1'b0; #1;
        check("R10 irq masked", irq, 0);
        irq_en = 1'b1; #1;
        check("R10 irq raised", irq, 1);
        wait_n(200);
        check("R9 flag sticky", flag, 1);
        pulse_clr();
        check("R9 flag cleared", flag, 0);
        check("R10 irq drops", irq, 0);
    endtask

    task automatic t_ratios();
        wr_ctrl(8'hC0);
        wr_cnt(1'b0, 8'h00);
        wait_n(20);
        check("R3 div2 after 20", count_lo, 10);
        wr_ctrl(8'hC7);
        wr_cnt(1'b0, 8'h00);
        wait_n(255);
        check("R3 div256 before step", count_lo, 0);
        wait_n(1);
        check("R3 div256 first step", count_lo, 1);
        wr_ctrl(8'hC8);
        wr_cnt(1'b0, 8'h00);
        wait_n(5);
        check("R3 bypass per clock", count_lo, 5);
    endtask

    task automatic t_prescaler_restart();
        wr_ctrl(8'hC2);
        wr_cnt(1'b0, 8'h00);
        wait_n(5);
        wr_cnt(1'b0, 8'h10);
        wait_n(7);
        check("R7 no early step", count_lo, 8'h10);
        wait_n(1);
        check("R7 step after full period", count_lo, 8'h11);
    endtask

    task automatic t_write_priority();
        wr_ctrl(8'hC8);
        wait_n(3);
        wr_cnt(1'b0, 8'h40);
        check("R8 write wins", count_lo, 8'h40);
        wait_n(1);
        check("R8 resumes", count_lo, 8'h41);
    endtask

    task automatic t_set_beats_clear();
        wr_ctrl(8'h00);
        pulse_clr();
        wr_ctrl(8'hC8);
        wr_cnt(1'b0, 8'hFF);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R9 set wins over clear", flag, 1);
        pulse_clr();
        check("R9 later clear", flag, 0);
    endtask

    task automatic t_narrow_hi();
        wr_ctrl(8'h48);
        pulse_clr();
        wr_cnt(1'b1, 8'h12);
        wr_cnt(1'b0, 8'hFF);
        wr_ctrl(8'hC8);
        wait_n(1);
        check("R4 lo wraps", count_lo, 0);
        check("R4 hi untouched", count_hi, 8'h12);
        check("R4 flag set", flag, 1);
    endtask

    task automatic t_wide();
        wr_ctrl(8'h08);
        pulse_clr();
        wr_cnt(1'b1, 8'h00);
        wr_cnt(1'b0, 8'hFF);
        wr_ctrl(8'h88);
        wait_n(1);
        check("R5 carry lo", count_lo, 0);
        check("R5 carry hi", count_hi, 1);
        check("R5 no flag at 00FF", flag, 0);
        wr_ctrl(8'h08);
        wr_cnt(1'b1, 8'hFF);
        wr_cnt(1'b0, 8'hFE);
        wr_ctrl(8'h88);
        wait_n(1);
        check("R5 at FFFF", {count_hi, count_lo}, 16'hFFFF);
        check("R5 flag not yet", flag, 0);
        wait_n(1);
        check("R5 wrap to 0000", {count_hi, count_lo}, 0);
        check("R5 flag at wrap", flag, 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ctrl_we = 0; cnt_we = 0; cnt_sel = 0; flag_clr = 0; irq_en = 0; wdata = '0;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        t_reset();
        t_disabled_hold();
        t_preload_period();
        t_ratios();
        t_prescaler_restart();
        t_write_priority();
        t_set_beats_clear();
        t_narrow_hi();
        t_wide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule